// File: doc/BRIEF.md
# Posit Word Field Decoder

This unit splits one posit word into its parts. A posit word has a sign bit, a regime field of variable length, up to `ES` exponent bits and a fraction. The regime is a run of identical bits, and its length sets where the exponent and the fraction start. The decoder finds that run, reads the exponent and fraction that follow it, and also reports the combined power-of-two scale. Its outputs suit a multiplier or accumulator that works on plain sign, scale and significand values.

The word width `N` (4 to 8) and the exponent width `ES` (0 to 2) are elaboration parameters. One word is accepted per cycle with `in_valid`. The decoded fields are registered and appear one cycle later with `out_valid`. The output stage is a two-state machine. `ST_EMPTY` means the output holds no fresh result and `ST_FULL` means it does. The transitions are:

- load: `ST_EMPTY` to `ST_FULL` when `in_valid` is high.
- stream: `ST_FULL` to `ST_FULL` when `in_valid` is high.
- drain: `ST_FULL` to `ST_EMPTY` when `in_valid` is low.
- idle: `ST_EMPTY` to `ST_EMPTY` when `in_valid` is low.

Top module: `posit_field_decoder`

## Requirements
- R1: `out_valid` is low after reset. A word presented with `in_valid` high at a rising edge has its decoded fields on the outputs, with `out_valid` high, from that edge until the next one. `out_valid` is low in the cycle after an edge where `in_valid` was low.
- R2: The all-zero word gives `out_zero`=1, `out_nar`=0 and `out_sign`=0, with regime, exponent, fraction and scale all 0.
- R3: The word with bit N-1 set and every other bit clear gives `out_nar`=1, `out_zero`=0 and `out_sign`=1, with regime, exponent, fraction and scale all 0.
- R4: `out_sign` equals bit N-1 of the word. When that bit is set, the fields are taken from the two's complement of the whole word.
- R5: The regime is read from bit N-2 downward in the (complemented) word. It is a run of m equal bits, ended by the opposite bit or by the end of the word. A run of zeros gives regime -m and a run of ones gives regime m-1. The output is signed two's complement.
- R6: The ES bits after the regime terminator form the unsigned exponent, with the first bit read as the most significant. Bits that lie beyond the end of the word read as 0. With ES=0 the one-bit exponent output is always 0.
- R7: `out_frac` is N-2 bits wide. Bit N-3 is the hidden one. Below it sit the bits that follow the exponent, left-aligned, with zeros filling the rest.
- R8: `out_scale` equals regime·2^ES + exponent, as a signed value.
- R9: A run of ones that fills all N-1 bits below the sign, with no terminator, gives regime N-2, exponent 0 and a fraction holding only the hidden one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word on `in_word` is to be decoded |
| in_word | input | N | Posit word |
| out_valid | output | 1 | Decoded fields are valid |
| out_sign | output | 1 | Sign bit |
| out_zero | output | 1 | Word is exact zero |
| out_nar | output | 1 | Word is Not-a-Real |
| out_regime | output | clog2(N)+1 | Signed regime value |
| out_expo | output | max(ES,1) | Unsigned exponent |
| out_frac | output | N-2 | Hidden one followed by the left-aligned fraction |
| out_scale | output | scale width | Signed regime·2^ES + exponent |

## Verification
Every result is due exactly one rising edge after the word is presented. The bench drives at the falling edge and pushes one expected entry per cycle into a queue, and an idle cycle also gets an entry. The monitor samples one time unit after each rising edge and pops the entry that was pushed before that edge. This way both the fields and the idle gaps in `out_valid` are checked against the cycle they belong to. All 2^N words are run through three decoders that differ only in ES (0, 1 and 2).

// File: rtl/posit_dec_pkg.sv
package posit_dec_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;

    function automatic int regime_w(int n);
        return $clog2(n) + 1;
    endfunction

    function automatic int expo_w(int es);
        return (es > 0) ? es : 1;
    endfunction

    function automatic int scale_w(int n, int es);
        return $clog2(((n - 1) << es) + 1) + 1;
    endfunction

endpackage

// File: rtl/posit_sign_fold.sv
module posit_sign_fold #(
    parameter int N = 8
) (
    input  logic [N-1:0] word_i,
    output logic         sign_o,
    output logic         zero_o,
    output logic         nar_o,
    output logic [N-2:0] body_o
);
    logic [N-1:0] magnitude;

    always_comb begin
        sign_o    = word_i[N-1];
        magnitude = sign_o ? (~word_i + N'(1)) : word_i;
        body_o    = magnitude[N-2:0];
        zero_o    = (word_i == '0);
        nar_o     = sign_o && (word_i[N-2:0] == '0);
    end
endmodule

// File: rtl/posit_run_scan.sv
module posit_run_scan #(
    parameter int N  = 8,
    parameter int CW = 3,
    parameter int KW = 4
) (
    input  logic [N-2:0]        body_i,
    output logic [CW-1:0]       run_o,
    output logic signed [KW-1:0] regime_o
);
    logic              lead;
    logic              ended;
    logic signed [KW-1:0] run_ext;

    always_comb begin
        lead  = body_i[N-2];
        run_o = '0;
        ended = 1'b0;
        for (int i = N - 2; i >= 0; i--) begin
            if (!ended && (body_i[i] == lead)) begin
                run_o = run_o + CW'(1);
            end else begin
                ended = 1'b1;
            end
        end
        run_ext  = $signed({1'b0, run_o});
        regime_o = lead ? (run_ext - KW'(1)) : -run_ext;
    end
endmodule

// File: rtl/posit_field_split.sv
module posit_field_split #(
    parameter int N  = 8,
    parameter int ES = 1,
    parameter int EW = 1,
    parameter int FW = 5,
    parameter int CW = 3,
    parameter int KW = 4,
    parameter int SW = 6
) (
    input  logic [N-2:0]         body_i,
    input  logic [CW-1:0]        run_i,
    input  logic signed [KW-1:0] regime_i,
    output logic [EW-1:0]        expo_o,
    output logic [FW:0]          frac_o,
    output logic signed [SW-1:0] scale_o
);
    logic [CW:0]  skip;
    logic [N-2:0] after_regime;
    logic [N-2:0] after_expo;
    logic signed [SW-1:0] regime_wide;
    logic signed [SW-1:0] expo_wide;

    always_comb begin
        skip         = {1'b0, run_i} + (CW + 1)'(1);
        after_regime = body_i << skip;
    end

    generate
        if (ES > 0) begin : g_expo
            always_comb begin
                expo_o     = after_regime[N-2 -: ES];
                after_expo = after_regime << ES;
            end
        end else begin : g_no_expo
            always_comb begin
                expo_o     = '0;
                after_expo = after_regime;
            end
        end
    endgenerate

    always_comb begin
        frac_o      = {1'b1, after_expo[N-2 -: FW]};
        regime_wide = SW'(regime_i);
        expo_wide   = $signed({{(SW - EW){1'b0}}, expo_o});
        scale_o     = (regime_wide <<< ES) + expo_wide;
    end
endmodule

// File: rtl/posit_field_decoder.sv
module posit_field_decoder
    import posit_dec_pkg::*;
#(
    parameter int N  = 8,
    parameter int ES = 1,
    localparam int KW = regime_w(N),
    localparam int EW = expo_w(ES),
    localparam int SW = scale_w(N, ES),
    localparam int FW = N - 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [N-1:0]         in_word,
    output logic                 out_valid,
    output logic                 out_sign,
    output logic                 out_zero,
    output logic                 out_nar,
    output logic signed [KW-1:0] out_regime,
    output logic [EW-1:0]        out_expo,
    output logic [FW:0]          out_frac,
    output logic signed [SW-1:0] out_scale
);
    localparam int CW = $clog2(N);

    stage_e state_q, state_d;

    logic                 sign_c, zero_c, nar_c;
    logic [N-2:0]         body_c;
    logic [CW-1:0]        run_c;
    logic signed [KW-1:0] regime_c;
    logic [EW-1:0]        expo_c;
    logic [FW:0]          frac_c;
    logic signed [SW-1:0] scale_c;
    logic                 special_c;

    posit_sign_fold #(.N(N)) u_fold (
        .word_i (in_word),
        .sign_o (sign_c),
        .zero_o (zero_c),
        .nar_o  (nar_c),
        .body_o (body_c)
    );

    posit_run_scan #(.N(N), .CW(CW), .KW(KW)) u_scan (
        .body_i   (body_c),
        .run_o    (run_c),
        .regime_o (regime_c)
    );

    posit_field_split #(
        .N(N), .ES(ES), .EW(EW), .FW(FW), .CW(CW), .KW(KW), .SW(SW)
    ) u_split (
        .body_i   (body_c),
        .run_i    (run_c),
        .regime_i (regime_c),
        .expo_o   (expo_c),
        .frac_o   (frac_c),
        .scale_o  (scale_c)
    );

    assign special_c = zero_c | nar_c;

    // Stage control: load / stream / drain / idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: captures a word's fields on every accepted word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_sign   <= 1'b0;
            out_zero   <= 1'b0;
            out_nar    <= 1'b0;
            out_regime <= '0;
            out_expo   <= '0;
            out_frac   <= '0;
            out_scale  <= '0;
        end else if (in_valid) begin
            out_sign   <= sign_c;
            out_zero   <= zero_c;
            out_nar    <= nar_c;
            out_regime <= special_c ? '0 : regime_c;
            out_expo   <= special_c ? '0 : expo_c;
            out_frac   <= special_c ? '0 : frac_c;
            out_scale  <= special_c ? '0 : scale_c;
        end
    end

    assign out_valid = (state_q == ST_FULL);
endmodule

// File: rtl/posit_field_decoder_chk.sv
module posit_field_decoder_chk #(
    parameter int N  = 8,
    parameter int ES = 1,
    parameter int KW = 4,
    parameter int EW = 1,
    parameter int SW = 6,
    parameter int FW = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [N-1:0]         in_word,
    input logic                 out_valid,
    input logic                 out_sign,
    input logic                 out_zero,
    input logic                 out_nar,
    input logic signed [KW-1:0] out_regime,
    input logic [EW-1:0]        out_expo,
    input logic [FW:0]          out_frac,
    input logic signed [SW-1:0] out_scale
);
    a_r1_load_shows_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_gap_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_zero_detect: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_zero == ($past(in_word) == '0)));

    a_r2_zero_fields_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_zero) |-> (!out_nar && !out_sign && out_regime == '0
            && out_expo == '0 && out_frac == '0 && out_scale == '0));

    a_r3_nar_fields_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nar) |-> (!out_zero && out_sign && out_regime == '0
            && out_expo == '0 && out_frac == '0 && out_scale == '0));

    a_r4_sign_tracks_word: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_sign == $past(in_word[N-1])));

    a_r5_regime_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_zero && !out_nar) |->
            (int'(out_regime) >= -(N - 1) && int'(out_regime) <= N - 2));

    a_r7_hidden_one: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_zero && !out_nar) |-> out_frac[FW]);

    a_r8_scale_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_zero && !out_nar) |->
            (int'(out_scale) == int'(out_regime) * (1 << ES) + int'(out_expo)));
endmodule

bind posit_field_decoder posit_field_decoder_chk #(
    .N(N), .ES(ES), .KW(KW), .EW(EW), .SW(SW), .FW(FW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .out_valid  (out_valid),
    .out_sign   (out_sign),
    .out_zero   (out_zero),
    .out_nar    (out_nar),
    .out_regime (out_regime),
    .out_expo   (out_expo),
    .out_frac   (out_frac),
    .out_scale  (out_scale)
);

// File: tb/posit_field_decoder_tb_top.sv
module posit_field_decoder_tb_top;
    import posit_dec_pkg::*;

    localparam int N        = 8;
    localparam int CLK_PER  = 10;
    localparam int WATCHDOG = 200000;

    typedef struct {
        bit valid;
        bit sgn;
        bit zero;
        bit nar;
        bit sat;
        int k;
        int e;
        int f;
        int sc;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_fail = 0;
    int   drivers_done = 0;

    always #(CLK_PER / 2) clk = ~clk;

    task automatic check(bit ok, string tag, int es, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (es=%0d): actual=%0d expected=%0d", tag, es, act, expv);
        end
    endtask

    function automatic exp_t idle_item();
        exp_t it;
        it = '{default: 0};
        return it;
    endfunction

    // Behavioural reference: walks the bits one at a time
    function automatic exp_t ref_decode(int es, logic [N-1:0] w);
        exp_t it;
        logic [N-1:0] v;
        int idx;
        int m;
        bit lead;
        it = '{default: 0};
        it.valid = 1'b1;
        it.sgn = w[N-1];
        if (w == '0) begin
            it.zero = 1'b1;
        end else if (w == {1'b1, {(N-1){1'b0}}}) begin
            it.nar = 1'b1;
        end else begin
            v = w[N-1] ? (~w + 1'b1) : w;
            idx = N - 2;
            lead = v[idx];
            m = 0;
            while (idx >= 0 && v[idx] == lead) begin
                m++;
                idx--;
            end
            it.sat = (m == N - 1);
            idx--;
            it.k = lead ? m - 1 : -m;
            for (int j = 0; j < es; j++) begin
                it.e = it.e * 2;
                if (idx >= 0) it.e = it.e + int'(v[idx]);
                idx--;
            end
            it.f = 1;
            for (int j = 0; j < N - 3; j++) begin
                it.f = it.f * 2;
                if (idx >= 0) it.f = it.f + int'(v[idx]);
                idx--;
            end
            it.sc = it.k * (1 << es) + it.e;
        end
        return it;
    endfunction

    generate
        for (genvar g = 0; g < 3; g++) begin : g_es
            localparam int ESG = g;
            localparam int KWG = regime_w(N);
            localparam int EWG = expo_w(ESG);
            localparam int SWG = scale_w(N, ESG);

            logic                  in_valid;
            logic [N-1:0]          in_word;
            logic                  out_valid, out_sign, out_zero, out_nar;
            logic signed [KWG-1:0] out_regime;
            logic [EWG-1:0]        out_expo;
            logic [N-3:0]          out_frac;
            logic signed [SWG-1:0] out_scale;
            exp_t                  q[$];

            posit_field_decoder #(.N(N), .ES(ESG)) dut_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .in_valid   (in_valid),
                .in_word    (in_word),
                .out_valid  (out_valid),
                .out_sign   (out_sign),
                .out_zero   (out_zero),
                .out_nar    (out_nar),
                .out_regime (out_regime),
                .out_expo   (out_expo),
                .out_frac   (out_frac),
                .out_scale  (out_scale)
            );

            // Driver: one queue entry per cycle, idle gaps included
            initial begin
                in_valid = 1'b0;
                in_word  = '0;
                wait (rst_n);
                for (int w = 0; w < (1 << N); w++) begin
                    if (w % 9 == 4) begin
                        @(negedge clk);
                        in_valid = 1'b0;
                        q.push_back(idle_item());
                    end
                    @(negedge clk);
                    in_valid = 1'b1;
                    in_word  = w[N-1:0];
                    q.push_back(ref_decode(ESG, w[N-1:0]));
                end
                @(negedge clk);
                in_valid = 1'b0;
                q.push_back(idle_item());
                drivers_done++;
            end

            // Monitor: sample just after each rising edge
            initial begin
                exp_t it;
                @(posedge clk);
                #1;
                check(out_valid == 1'b0, "R1 reset valid", ESG, int'(out_valid), 0);
                wait (rst_n);
                forever begin
                    @(posedge clk);
                    #1;
                    if (q.size() > 0) begin
                        it = q.pop_front();
                        check(out_valid == it.valid, "R1 valid timing", ESG,
                              int'(out_valid), int'(it.valid));
                        if (it.valid) begin
                            check(out_zero == it.zero, "R2 zero flag", ESG,
                                  int'(out_zero), int'(it.zero));
                            check(out_nar == it.nar, "R3 nar flag", ESG,
                                  int'(out_nar), int'(it.nar));
                            check(out_sign == it.sgn, "R4 sign", ESG,
                                  int'(out_sign), int'(it.sgn));
                            check(int'(out_regime) == it.k,
                                  it.sat ? "R9 saturated regime" : "R5 regime", ESG,
                                  int'(out_regime), it.k);
                            check(int'(out_expo) == it.e, "R6 exponent", ESG,
                                  int'(out_expo), it.e);
                            check(int'(out_frac) == it.f, "R7 fraction", ESG,
                                  int'(out_frac), it.f);
                            check(int'(out_scale) == it.sc, "R8 scale", ESG,
                                  int'(out_scale), it.sc);
                        end
                    end
                end
            end
        end
    endgenerate

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wait (drivers_done == 3);
        repeat (4) @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PER * WATCHDOG);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule